// File: doc/BRIEF.md
# Binary Bit-Plane Motion Estimator

This block finds the best displacement for one 16x16 block of a binary (one bit per pixel) image. A full search covers every offset from -16 to +15 both across and down, which is 1024 candidates. Each candidate is scored by XOR-ing the block against the displaced window pixels and counting the set bits. Scoring uses single-bit logic and a bit count only; pixel values are never subtracted.

The block is given the current block as 16-bit rows and the search window as 47-bit rows, each stream under its own valid/ready pair. These rows are held in row shift registers, and no RAM is used. During the search the window register moves up one row for each vertical step. Two cores share one loading port and take turns. One core can take in the next block while the other core is still searching. Each finished search produces a one-cycle pulse carrying the displacement and its mismatch count.

Top module: `bitplane_me`

## Requirements
- R1: The mismatch of a candidate is the number of the 256 block pixels whose bit differs from the displaced window bit. It lies in 0..256 and is reported on the 9-bit `mvCost`.
- R2: In a current row, bit j is column j. In a window row, bit i is column i. The first row sent in each stream is the top row. The candidate (x, y) compares block pixel (row r, column j) with window pixel (row r+y+16, column j+x+16).
- R3: The reported displacement has the lowest mismatch. If several candidates tie, the first one in raster order wins. Raster order runs y in the outer loop and x in the inner loop, each from -16 upward.
- R4: `mvX` and `mvY` are 6-bit two's complement values in the range -16..+15.
- R5: Each loaded block gives exactly one `mvValid` pulse, one cycle long. Results come out in the order the blocks were loaded.
- R6: A `start` is taken only when no load is in progress and the core due to load next is idle. Any other `start` is ignored, and both ready outputs stay low.
- R7: A row is taken on a cycle where its valid and ready are both high. `curReady` stays high until 16 rows are taken, and `refReady` until 47 rows are taken. The two streams can interleave freely. Valid inputs have no effect while no load is in progress.
- R8: The cores alternate. Two blocks loaded back to back give results separated by about one load time, not by a whole search.
- R9: After reset, `curReady`, `refReady` and `mvValid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin loading the next block |
| curValid | input | 1 | Current-block row is valid |
| curReady | output | 1 | Current-block row can be taken |
| curRow | input | 16 | Current-block row, bit j = column j |
| refValid | input | 1 | Window row is valid |
| refReady | output | 1 | Window row can be taken |
| refRow | input | 47 | Window row, bit i = column i |
| mvValid | output | 1 | One-cycle result pulse |
| mvX | output | 6 | Horizontal displacement, two's complement |
| mvY | output | 6 | Vertical displacement, two's complement |
| mvCost | output | 9 | Mismatch count of the chosen displacement |

## Verification
Two things can happen in the same cycle: one core takes rows for a new block while the other core finishes its search and drives the result pulse. The bench loads blocks back to back, so each new load starts as soon as a core frees up. This places the partner core's report inside or right next to that load window. Each result is judged against a brute-force search that the bench runs over the same random binary frames. The bench also checks that pulses arrive in load order, one cycle long, with the expected spacing. A `start` issued while both cores are busy must leave the ready outputs low.

// File: rtl/bitplane_me_pkg.sv
package bitplane_me_pkg;
  localparam int BLK   = 16;                 // block edge in pixels
  localparam int RANGE = 16;                 // offsets span -RANGE..RANGE-1
  localparam int NPOS  = 2 * RANGE;          // positions per axis
  localparam int WIN   = BLK + NPOS - 1;     // window edge in pixels
  localparam int NCORE = 2;
  localparam int OFFW  = $clog2(NPOS);
  localparam int MVW   = OFFW + 1;
  localparam int COSTW = $clog2(BLK * BLK + 1);
  localparam int CURCW = $clog2(BLK + 1);
  localparam int REFCW = $clog2(WIN + 1);

  typedef struct packed {
    logic            shiftCur;
    logic            shiftRef;
    logic            search;
    logic            first;
    logic [OFFW-1:0] dx;
    logic [OFFW-1:0] dy;
  } coreStrobe_t;
endpackage

// File: rtl/bitplane_me_ctrl.sv
module bitplane_me_ctrl
  import bitplane_me_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic                    curValid,
  input  logic                    refValid,
  output logic                    curReady,
  output logic                    refReady,
  output coreStrobe_t [NCORE-1:0] strb,
  output logic [NCORE-1:0]        reportVec
);
  logic             loading;
  logic             loadSel;
  logic [CURCW-1:0] curCnt;
  logic [REFCW-1:0] refCnt;
  logic [NCORE-1:0] searching;
  logic [NCORE-1:0] done;
  logic [2*OFFW-1:0] cnt [NCORE];
  logic curTake, refTake, loadFull, startOk;

  assign curReady = loading && (curCnt != CURCW'(BLK));
  assign refReady = loading && (refCnt != REFCW'(WIN));
  assign curTake  = curValid && curReady;
  assign refTake  = refValid && refReady;
  assign loadFull = loading && (curCnt == CURCW'(BLK)) && (refCnt == REFCW'(WIN));
  assign startOk  = start && !loading && !searching[loadSel] && !done[loadSel];
  assign reportVec = done;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loading   <= 1'b0;
      loadSel   <= 1'b0;
      curCnt    <= '0;
      refCnt    <= '0;
      searching <= '0;
      done      <= '0;
      for (int c = 0; c < NCORE; c++) cnt[c] <= '0;
    end else begin
      if (startOk) begin
        loading <= 1'b1;
        curCnt  <= '0;
        refCnt  <= '0;
      end
      if (curTake) curCnt <= curCnt + 1'b1;
      if (refTake) refCnt <= refCnt + 1'b1;
      for (int c = 0; c < NCORE; c++) begin
        done[c] <= 1'b0;
        if (searching[c]) begin
          cnt[c] <= cnt[c] + 1'b1;
          if (cnt[c] == '1) begin
            searching[c] <= 1'b0;
            done[c]      <= 1'b1;
          end
        end
      end
      if (loadFull) begin
        loading            <= 1'b0;
        searching[loadSel] <= 1'b1;
        cnt[loadSel]       <= '0;
        loadSel            <= ~loadSel;
      end
    end
  end

  always_comb begin
    for (int c = 0; c < NCORE; c++) begin
      strb[c].search   = searching[c];
      strb[c].first    = (cnt[c] == '0);
      strb[c].dx       = cnt[c][OFFW-1:0];
      strb[c].dy       = cnt[c][2*OFFW-1:OFFW];
      strb[c].shiftCur = curTake && (loadSel == 1'(c));
      strb[c].shiftRef = (refTake && (loadSel == 1'(c))) ||
                         (searching[c] && (cnt[c][OFFW-1:0] == '1));
    end
  end

  a_r6_no_load_into_busy: assert property (@(posedge clk) disable iff (!rstN)
    loading |-> (!searching[loadSel] && !done[loadSel]));
  a_r5_one_report: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(done));
  a_r5_pulse_short: assert property (@(posedge clk) disable iff (!rstN)
    (|done) |=> !(|done));
  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    (curCnt <= CURCW'(BLK)) && (refCnt <= REFCW'(WIN)));
endmodule

// File: rtl/bitplane_me_dp.sv
module bitplane_me_dp
  import bitplane_me_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  coreStrobe_t      strb,
  input  logic [BLK-1:0]   curRow,
  input  logic [WIN-1:0]   refRow,
  output logic [COSTW-1:0] bestCost,
  output logic [MVW-1:0]   bestMvX,
  output logic [MVW-1:0]   bestMvY
);
  logic [BLK-1:0]   curBuf [BLK];
  logic [WIN-1:0]   winBuf [WIN];
  logic [COSTW-1:0] cost;

  always_ff @(posedge clk) begin
    if (strb.shiftCur) begin
      for (int r = 0; r < BLK - 1; r++) curBuf[r] <= curBuf[r+1];
      curBuf[BLK-1] <= curRow;
    end
    if (strb.shiftRef) begin
      for (int r = 0; r < WIN - 1; r++) winBuf[r] <= winBuf[r+1];
      winBuf[WIN-1] <= strb.search ? '0 : refRow;
    end
  end

  always_comb begin
    cost = '0;
    for (int r = 0; r < BLK; r++)
      for (int j = 0; j < BLK; j++)
        cost = cost + COSTW'(curBuf[r][j] ^ winBuf[r][int'(strb.dx) + j]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bestCost <= '0;
      bestMvX  <= '0;
      bestMvY  <= '0;
    end else if (strb.search && (strb.first || cost < bestCost)) begin
      bestCost <= cost;
      bestMvX  <= MVW'({1'b0, strb.dx}) - MVW'(RANGE);
      bestMvY  <= MVW'({1'b0, strb.dy}) - MVW'(RANGE);
    end
  end

  a_r1_cost_range: assert property (@(posedge clk) disable iff (!rstN)
    bestCost <= COSTW'(BLK * BLK));
  a_r3_best_never_rises: assert property (@(posedge clk) disable iff (!rstN)
    (strb.search && !strb.first) |=> (bestCost <= $past(bestCost)));
  a_r4_mv_range: assert property (@(posedge clk) disable iff (!rstN)
    ($signed(bestMvX) >= -RANGE) && ($signed(bestMvX) < RANGE) &&
    ($signed(bestMvY) >= -RANGE) && ($signed(bestMvY) < RANGE));
endmodule

// File: rtl/bitplane_me.sv
module bitplane_me
  import bitplane_me_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             curValid,
  output logic             curReady,
  input  logic [BLK-1:0]   curRow,
  input  logic             refValid,
  output logic             refReady,
  input  logic [WIN-1:0]   refRow,
  output logic             mvValid,
  output logic [MVW-1:0]   mvX,
  output logic [MVW-1:0]   mvY,
  output logic [COSTW-1:0] mvCost
);
  coreStrobe_t [NCORE-1:0] strb;
  logic [NCORE-1:0]        reportVec;
  logic [COSTW-1:0]        coreCost [NCORE];
  logic [MVW-1:0]          coreX [NCORE];
  logic [MVW-1:0]          coreY [NCORE];

  bitplane_me_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .start(start),
    .curValid(curValid), .refValid(refValid),
    .curReady(curReady), .refReady(refReady),
    .strb(strb), .reportVec(reportVec)
  );

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    bitplane_me_dp dp_i (
      .clk(clk), .rstN(rstN), .strb(strb[c]),
      .curRow(curRow), .refRow(refRow),
      .bestCost(coreCost[c]), .bestMvX(coreX[c]), .bestMvY(coreY[c])
    );
  end

  always_comb begin
    mvValid = 1'b0;
    mvX     = '0;
    mvY     = '0;
    mvCost  = '0;
    for (int c = 0; c < NCORE; c++) begin
      if (reportVec[c]) begin
        mvValid = 1'b1;
        mvX     = coreX[c];
        mvY     = coreY[c];
        mvCost  = coreCost[c];
      end
    end
  end
endmodule

// File: tb/bitplane_me_tb.sv
`timescale 1ns/1ps
module bitplane_me_tb_top;
  import bitplane_me_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, curValid = 1'b0, refValid = 1'b0;
  logic [BLK-1:0] curRow = '0;
  logic [WIN-1:0] refRow = '0;
  logic curReady, refReady, mvValid;
  logic [MVW-1:0] mvX, mvY;
  logic [COSTW-1:0] mvCost;

  always #2 clk = ~clk;

  bitplane_me dut_i (
    .clk(clk), .rstN(rstN), .start(start),
    .curValid(curValid), .curReady(curReady), .curRow(curRow),
    .refValid(refValid), .refReady(refReady), .refRow(refRow),
    .mvValid(mvValid), .mvX(mvX), .mvY(mvY), .mvCost(mvCost)
  );

  // seed, planted x, planted y, mode (0 planted, 1 random, 2 zeros, 3 ones vs zeros)
  localparam int NT = 8;
  localparam int TBL [NT][4] = '{
    '{32'h1234,  3,  -2, 0}, '{77, -16, -16, 0}, '{91, 15, 15, 0}, '{5, 15, -16, 0},
    '{13, 0, 0, 1}, '{1, 0, 0, 2}, '{2, 0, 0, 3}, '{99, -7, 11, 0}};

  int nChecks = 0, nErr = 0, cycle = 0, nExp = 0, nGot = 0;
  int expX [NT], expY [NT], expC [NT];
  int stamp [NT];
  logic prevValid = 1'b0;
  logic [BLK-1:0] cf [BLK];
  logic [WIN-1:0] rf [WIN];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] t = s;
    t ^= t << 13; t ^= t >> 17; t ^= t << 5;
    return t;
  endfunction

  task automatic buildFrame(input int seed, input int px, input int py, input int mode);
    logic [31:0] s = seed;
    logic [31:0] a;
    for (int r = 0; r < BLK; r++) begin
      s = nxt(s);
      cf[r] = (mode == 2) ? '0 : (mode == 3) ? '1 : s[BLK-1:0];
    end
    for (int r = 0; r < WIN; r++) begin
      s = nxt(s); a = s; s = nxt(s);
      rf[r] = (mode >= 2) ? '0 : {a[WIN-33:0], s};
    end
    if (mode == 0)
      for (int r = 0; r < BLK; r++)
        for (int j = 0; j < BLK; j++)
          rf[r+py+RANGE][j+px+RANGE] = cf[r][j];
  endtask

  // brute-force full search, strict less keeps the first in raster order (R3)
  task automatic bruteForce();
    int best = 100000, bx = 0, by = 0;
    for (int dy = 0; dy < NPOS; dy++)
      for (int dx = 0; dx < NPOS; dx++) begin
        int c = 0;
        for (int r = 0; r < BLK; r++) c += $countones(cf[r] ^ rf[r+dy][dx +: BLK]);
        if (c < best) begin best = c; bx = dx - RANGE; by = dy - RANGE; end
      end
    expX[nExp] = bx; expY[nExp] = by; expC[nExp] = best;
    nExp++;
  endtask

  task automatic loadFrame();
    int ci = 0, ri = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!curReady) begin
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (ci < BLK || ri < WIN) begin
      curValid = (ci < BLK) && curReady && ((ci + ri) % 3 != 2);
      refValid = (ri < WIN) && refReady;
      curRow = cf[ci % BLK];
      refRow = rf[ri % WIN];
      @(negedge clk);
      if (curValid) ci++;
      if (refValid) ri++;
      curValid = 1'b0;
      refValid = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    cycle++;
    if (rstN) begin
      chk(!(mvValid && prevValid), "R5", "pulse longer than one cycle", 1, 0);
      if (mvValid) begin
        if (nGot < nExp) begin
          chk(int'($signed(mvX)) == expX[nGot], "R3", "mvX", int'($signed(mvX)), expX[nGot]);
          chk(int'($signed(mvY)) == expY[nGot], "R4", "mvY", int'($signed(mvY)), expY[nGot]);
          chk(int'(mvCost) == expC[nGot], "R1", "mvCost", int'(mvCost), expC[nGot]);
          stamp[nGot] = cycle;
        end else chk(1'b0, "R5", "unexpected result", nGot, nExp);
        nGot++;
      end
    end
    prevValid = mvValid;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R5", "watchdog expired", nGot, nExp);
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R9 reset state
    chk(!curReady, "R9", "curReady in reset", curReady, 0);
    chk(!refReady, "R9", "refReady in reset", refReady, 0);
    chk(!mvValid, "R9", "mvValid in reset", mvValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    // R7 valid inputs while idle have no effect
    curValid = 1'b1; refValid = 1'b1; curRow = '1; refRow = '1;
    repeat (5) begin
      @(negedge clk);
      chk(!curReady && !refReady, "R7", "ready while idle", curReady, 0);
    end
    curValid = 1'b0; refValid = 1'b0;
    for (int i = 0; i < NT; i++) begin
      buildFrame(TBL[i][0], TBL[i][1], TBL[i][2], TBL[i][3]);
      bruteForce();
      loadFrame();
      if (i % 2 == 1) begin
        // R6 both cores busy: start is ignored
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!curReady, "R6", "curReady after start with cores busy", curReady, 0);
        chk(!refReady, "R6", "refReady after start with cores busy", refReady, 0);
      end
    end
    while (nGot < NT) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(nGot == NT, "R5", "result count", nGot, NT);
    // R8 first pair finishes about one load time apart
    chk((stamp[1] - stamp[0]) > 0 && (stamp[1] - stamp[0]) < 200, "R8",
        "gap between paired results", stamp[1] - stamp[0], 60);
    // R2 planted block at a corner offset is found with zero cost
    chk(expC[1] == 0 && expX[1] == -16 && expY[1] == -16, "R2", "planted corner", expX[1], -16);
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule